// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block produces the micro-address of a microcoded control unit. It keeps a micro-address register and an incrementer. Each cycle it chooses the next micro-address from one of four sources: the incremented current address, the start address that the opcode decoder maps from the instruction, an address supplied from outside, or the jump target carried in the current microword. The control store and the opcode-mapping table sit outside the block. The current microword's sequencing fields, the mapping output and the external address are all inputs. The register output drives the control store's read address.

A two-bit source code in the microword names the source. Five condition enables qualify that code. The named source is used only when one of the enabled tests on the zero flag (Z) and sign flag (N) is true. In every other case the sequencer steps to the next sequential address. Source code 00 always steps. The microword's datapath control bits pass straight through to the output.

The external address serves three purposes: it starts instruction fetch, it enters interrupt service, and it is the value the register takes at reset.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `uaddr_o` takes the value of `ext_addr_i` at that edge.
- R2: With `sel_i` = 00, the next `uaddr_o` is the current `uaddr_o` plus one, whatever the condition bits and flags are.
- R3: With `sel_i` = 01 and the branch condition true, the next `uaddr_o` is `map_addr_i`.
- R4: With `sel_i` = 10 and the branch condition true, the next `uaddr_o` is `ext_addr_i`.
- R5: With `sel_i` = 11 and the branch condition true, the next `uaddr_o` is `br_addr_i`.
- R6: With a nonzero `sel_i` and the branch condition false, the next `uaddr_o` is the current `uaddr_o` plus one.
- R7: `cond_i` bits each enable one test: bit 0 is always true, bit 1 is Z=0, bit 2 is Z=1, bit 3 is N=0 and bit 4 is N=1. The branch condition is the OR of all enabled tests.
- R8: With a nonzero `sel_i` and `cond_i` = 00000, the sequencer steps to the current address plus one.
- R9: Stepping from the all-ones address gives address zero.
- R10: `ctrl_o` equals `ctrl_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `ext_addr_i` |
| sel_i | input | 2 | Microword source code (00 step, 01 mapped, 10 external, 11 jump target) |
| cond_i | input | 5 | Microword condition enables (see R7) |
| zero_i | input | 1 | Zero flag Z |
| sign_i | input | 1 | Sign flag N |
| br_addr_i | input | AW | Jump target field of the microword |
| map_addr_i | input | AW | Start address from the opcode-mapping table |
| ext_addr_i | input | AW | Externally supplied address |
| ctrl_i | input | CW | Datapath control bits of the microword |
| uaddr_o | output | AW | Current micro-address to the control store |
| ctrl_o | output | CW | Datapath control bits, passed through |

## Verification
The only state is the micro-address register, and every next address is computed from it. A wrong value in the register therefore shows on `uaddr_o` at once. Its effect spreads to the following address one clock later. A fault in the condition logic or the source selector shows on `uaddr_o` one edge after the microword that triggers it. The bench compares every cycle against a model, so such a fault is reported in the cycle in which it first appears.

// File: rtl/useq_pkg.sv
// Shared definitions for the microprogram sequencer.
// Assumes the source-select encoding is fixed by the microcode format.
package useq_pkg;

    // Next-address source named by the microword
    typedef enum logic [1:0] {
        SRC_STEP = 2'b00,
        SRC_MAP  = 2'b01,
        SRC_EXT  = 2'b10,
        SRC_JUMP = 2'b11
    } src_e;

    // Positions of the condition enables in the microword
    localparam int COND_W    = 5;
    localparam int CI_ALWAYS = 0;
    localparam int CI_ZCLR   = 1;
    localparam int CI_ZSET   = 2;
    localparam int CI_NCLR   = 3;
    localparam int CI_NSET   = 4;

endpackage

// File: rtl/useq_cond_eval.sv
// Condition evaluator: compares the microword's condition enables with the
// zero and sign flags and reports whether the selected source is to be taken.
// Assumes the flags are stable before the clock edge. Several enables are ORed.
module useq_cond_eval
    import useq_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic              zero_i,
    input  logic              sign_i,
    output logic              take_o
);

    logic [COND_W-1:0] test_true;

    // Form the outcome of every individual test
    always_comb begin
        test_true            = '0;
        test_true[CI_ALWAYS] = 1'b1;
        test_true[CI_ZCLR]   = ~zero_i;
        test_true[CI_ZSET]   = zero_i;
        test_true[CI_NCLR]   = ~sign_i;
        test_true[CI_NSET]   = sign_i;
    end

    // Taken when any enabled test is true
    always_comb begin
        take_o = |(cond_i & test_true);
    end

endmodule

// File: rtl/useq_next_mux.sv
// Source selector: picks the next micro-address from four candidates.
// Assumes the step address is always the fallback: select 00 or a failed
// condition yields it.
module useq_next_mux
    import useq_pkg::*;
#(
    parameter int AW = 9
) (
    input  src_e          sel_i,
    input  logic          take_i,
    input  logic [AW-1:0] step_addr_i,
    input  logic [AW-1:0] map_addr_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic [AW-1:0] br_addr_i,
    output logic [AW-1:0] next_addr_o
);

    localparam int NSRC = 4;

    logic [AW-1:0] cand [NSRC];

    // Gather candidates in the order of the source code
    always_comb begin
        cand[SRC_STEP] = step_addr_i;
        cand[SRC_MAP]  = map_addr_i;
        cand[SRC_EXT]  = ext_addr_i;
        cand[SRC_JUMP] = br_addr_i;
    end

    // Use the named candidate only when the condition holds
    always_comb begin
        if (take_i) begin
            next_addr_o = cand[sel_i];
        end else begin
            next_addr_o = step_addr_i;
        end
    end

endmodule

// File: rtl/useq_addr_reg.sv
// Micro-address register with incrementer. Reset loads the external address.
// Assumes the incrementer wraps modulo 2**AW.
module useq_addr_reg #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr_i,
    input  logic [AW-1:0] next_addr_i,
    output logic [AW-1:0] uaddr_o,
    output logic [AW-1:0] step_addr_o
);

    // Hold the current micro-address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uaddr_o <= ext_addr_i;
        end else begin
            uaddr_o <= next_addr_i;
        end
    end

    // Sequential successor with wrap-around
    always_comb begin
        step_addr_o = uaddr_o + AW'(1);
    end

endmodule

// File: rtl/useq_sequencer.sv
// Top of the microprogram sequencer. Chooses the next micro-address from
// step / mapped / external / jump sources, qualified by flag conditions.
// Assumes the control store and opcode map are external; control bits pass
// through unchanged.
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int AW = 9,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              zero_i,
    input  logic              sign_i,
    input  logic [AW-1:0]     br_addr_i,
    input  logic [AW-1:0]     map_addr_i,
    input  logic [AW-1:0]     ext_addr_i,
    input  logic [CW-1:0]     ctrl_i,
    output logic [AW-1:0]     uaddr_o,
    output logic [CW-1:0]     ctrl_o
);

    logic          take;
    logic          take_qual;
    logic [AW-1:0] step_addr;
    logic [AW-1:0] next_addr;
    src_e          sel;

    // Decode the raw select field
    always_comb begin
        sel       = src_e'(sel_i);
        take_qual = take && (sel != SRC_STEP);
    end

    useq_cond_eval u_cond (
        .cond_i (cond_i),
        .zero_i (zero_i),
        .sign_i (sign_i),
        .take_o (take)
    );

    useq_next_mux #(.AW(AW)) u_mux (
        .sel_i       (sel),
        .take_i      (take_qual),
        .step_addr_i (step_addr),
        .map_addr_i  (map_addr_i),
        .ext_addr_i  (ext_addr_i),
        .br_addr_i   (br_addr_i),
        .next_addr_o (next_addr)
    );

    useq_addr_reg #(.AW(AW)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr_i  (ext_addr_i),
        .next_addr_i (next_addr),
        .uaddr_o     (uaddr_o),
        .step_addr_o (step_addr)
    );

    // Datapath control bits are not touched
    always_comb begin
        ctrl_o = ctrl_i;
    end

endmodule

// File: rtl/useq_sequencer_chk.sv
// Assertion checker for the microprogram sequencer, bound to the top.
module useq_sequencer_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    sel_i,
    input logic [4:0]    cond_i,
    input logic          zero_i,
    input logic          sign_i,
    input logic [AW-1:0] br_addr_i,
    input logic [AW-1:0] map_addr_i,
    input logic [AW-1:0] ext_addr_i,
    input logic [AW-1:0] uaddr_o
);

    // R1
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> uaddr_o == $past(ext_addr_i));

    // R2
    step_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == 2'b00 |=> uaddr_o == AW'($past(uaddr_o) + 1'b1));

    // R3
    map_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b01 && cond_i[0]) |=> uaddr_o == $past(map_addr_i));

    // R4
    ext_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b10 && cond_i[2] && zero_i) |=> uaddr_o == $past(ext_addr_i));

    // R5
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b11 && cond_i[0]) |=> uaddr_o == $past(br_addr_i));

    // R6
    jump_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b11 && cond_i == 5'b10000 && !sign_i)
        |=> uaddr_o == AW'($past(uaddr_o) + 1'b1));

    // R8
    no_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != 2'b00 && cond_i == 5'b00000)
        |=> uaddr_o == AW'($past(uaddr_o) + 1'b1));

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b00 && uaddr_o == {AW{1'b1}}) |=> uaddr_o == '0);

endmodule

bind useq_sequencer useq_sequencer_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .cond_i     (cond_i),
    .zero_i     (zero_i),
    .sign_i     (sign_i),
    .br_addr_i  (br_addr_i),
    .map_addr_i (map_addr_i),
    .ext_addr_i (ext_addr_i),
    .uaddr_o    (uaddr_o)
);

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
    localparam int AW = 9;
    localparam int CW = 16;
    localparam int AMAX = 1 << AW;

    logic          clk;
    logic          rst_n;
    logic [1:0]    sel_i;
    logic [4:0]    cond_i;
    logic          zero_i;
    logic          sign_i;
    logic [AW-1:0] br_addr_i;
    logic [AW-1:0] map_addr_i;
    logic [AW-1:0] ext_addr_i;
    logic [CW-1:0] ctrl_i;
    logic [AW-1:0] uaddr_o;
    logic [CW-1:0] ctrl_o;

    int    n_chk = 0;
    int    n_fail = 0;
    int    exp_addr = 0;
    int    exp_next = 0;
    string exp_tag = "";
    bit    done = 0;

    useq_sequencer #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .cond_i(cond_i),
        .zero_i(zero_i), .sign_i(sign_i), .br_addr_i(br_addr_i),
        .map_addr_i(map_addr_i), .ext_addr_i(ext_addr_i), .ctrl_i(ctrl_i),
        .uaddr_o(uaddr_o), .ctrl_o(ctrl_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Behavioural next-address model taken from the requirements
    function automatic int model_next(input bit r, input int s, input int c,
                                      input bit z, input bit n, input int m,
                                      input int e, input int b, input int cur,
                                      output string tag);
        bit ok;
        int stepv;
        stepv = (cur + 1) % AMAX;
        if (!r) begin tag = "R1"; return e; end
        if (s == 0) begin
            tag = (cur == AMAX - 1) ? "R9" : "R2";
            return stepv;
        end
        if (c == 0) begin tag = "R8"; return stepv; end
        ok = c[0] || (c[1] && !z) || (c[2] && z) || (c[3] && !n) || (c[4] && n);
        if (!ok) begin tag = "R6/R7"; return stepv; end
        case (s)
            1: tag = (c == 1) ? "R3" : "R3/R7";
            2: tag = (c == 1) ? "R4" : "R4/R7";
            default: tag = (c == 1) ? "R5" : "R5/R7";
        endcase
        return (s == 1) ? m : (s == 2) ? e : b;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Drive one microword, check pass-through, clock it, check the address
    task automatic step(input bit r, input int s, input int c, input bit z,
                        input bit n, input int m, input int e, input int b);
        logic [CW-1:0] cv;
        cv = CW'($urandom);
        rst_n = r; sel_i = 2'(s); cond_i = 5'(c); zero_i = z; sign_i = n;
        map_addr_i = AW'(m); ext_addr_i = AW'(e); br_addr_i = AW'(b);
        ctrl_i = cv;
        exp_next = model_next(r, s, c, z, n, m, e, b, exp_addr, exp_tag);
        #1;
        check("R10", int'(ctrl_o), int'(cv));
        @(posedge clk);
        @(negedge clk);
        exp_addr = exp_next;
        check(exp_tag, int'(uaddr_o), exp_addr);
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel_i = '0; cond_i = '0; zero_i = 0; sign_i = 0;
        br_addr_i = '0; map_addr_i = '0; ext_addr_i = '0; ctrl_i = '0;
        @(negedge clk);
        // R1: reset loads the external start address
        step(0, 3, 1, 0, 0, 7, 200, 9);
        step(0, 0, 0, 0, 0, 0, 200, 0);
        // Small microprogram with a test-and-loop
        for (int k = 0; k < 12; k++) begin
            bit nf;
            nf = (k < 8);
            case (exp_addr)
                200: step(1, 0, 0, 0, nf, 0, 400, 0);            // R2
                201: step(1, 1, 1, 0, nf, 202, 400, 0);          // R3
                202: step(1, 2, 4, 0, nf, 0, 400, 0);            // R6 Z clear
                203: step(1, 3, 16, 0, 0, 0, 400, 300);         // R6 N clear
                204: step(1, 3, 8, 0, nf, 0, 400, 206);         // loop test
                205: step(1, 3, 1, 0, nf, 0, 400, 204);         // R5 back
                default: step(1, 0, 0, 0, 0, 0, 0, 0);
            endcase
        end
        // R4 taken on Z, R5 taken on N
        step(1, 2, 4, 1, 0, 0, 77, 0);
        step(1, 3, 16, 0, 1, 0, 0, 300);
        // R7: several enables ORed, R8: none enabled
        step(1, 3, 5'b00110, 1, 0, 0, 0, 123);
        step(1, 1, 0, 1, 1, 55, 66, 77);
        // R9: wrap from the top address
        step(1, 3, 1, 0, 0, 0, 0, AMAX - 1);
        step(1, 0, 31, 1, 1, 1, 2, 3);
        // Random microwords
        for (int k = 0; k < 4000; k++) begin
            int c;
            int mode;
            mode = $urandom_range(0, 3);
            if (mode == 0) c = 0;
            else if (mode == 1) c = $urandom_range(0, 31);
            else c = 1 << $urandom_range(0, 4);
            step(($urandom_range(0, 49) != 0), $urandom_range(0, 3), c,
                 1'($urandom), 1'($urandom), $urandom_range(0, AMAX - 1),
                 $urandom_range(0, AMAX - 1), $urandom_range(0, AMAX - 1));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule